// File: doc/BRIEF.md
# Banked Data Fault Status Register

This block records why the most recent data access aborted. It holds two independent 32-bit copies of the record, one for the Secure world and one for the Non-secure world. When the memory system reports an abort, the block stores the fault status code, the extra status bit, the domain number, the access direction and, for external aborts, the decode-versus-slave error flag. The store goes into the copy of the current security state. If the abort is imprecise, only the status code is replaced.

Software reads and writes the copy of its current security state through a simple register-access port. Only privileged code may use this port. An unprivileged attempt raises an error flag, reads back zero and changes nothing. An external abort that enters monitor mode while external-abort routing is enabled is always stored in the Secure copy.

Top module: `fault_status_bank`

## Requirements
- R1: After reset, both copies hold zero, `reg_rdata` is zero and `reg_acc_err` is low.
- R2: A precise abort capture writes the record fields to these positions: bit 12 holds the slave flag, bit 11 holds direction (1 = write), bit 10 holds the extra status bit, bits 7:4 hold the domain and bits 3:0 hold the code.
- R3: When a precise abort is not external, bit 12 is stored as 0 whatever `abt_slave_err` is.
- R4: An imprecise abort replaces only bits 3:0 of the target copy. Bits 12:4 keep their previous values.
- R5: Captures and software accesses use the Secure copy when `cur_secure` = 1 and the Non-secure copy when it is 0.
- R6: An abort with `abt_external` = 1, `mon_entry` = 1 and `ea_route_mon` = 1 is stored in the Secure copy even when `cur_secure` = 0. The Non-secure copy is left unchanged.
- R7: A privileged write stores `reg_wdata` bits 12, 11, 10 and 7:0. Bits 31:13 and 9:8 are discarded and always read as zero.
- R8: A read with `reg_rd_en` = 1 loads `reg_rdata` at the next clock edge. A privileged read loads the selected copy as it stood before that edge. An unprivileged read loads zero. `reg_rdata` holds its value between reads.
- R9: If `reg_rd_en` or `reg_wr_en` is high while `cur_priv` = 0, `reg_acc_err` is high in the following cycle, and the write has no effect.
- R10: When an abort capture and a privileged write target the same copy in the same cycle, the capture is stored and the write is dropped. A write to the other copy still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abt_valid | input | 1 | Data abort event this cycle |
| abt_code | input | 4 | Fault status code |
| abt_code_ext | input | 1 | Extra status bit |
| abt_domain | input | 4 | Domain number 0 to 15 |
| abt_write | input | 1 | 1 = a write caused the abort |
| abt_slave_err | input | 1 | 1 = slave error, 0 = decode error |
| abt_imprecise | input | 1 | Abort is imprecise |
| abt_external | input | 1 | Abort is external |
| cur_secure | input | 1 | 1 = Secure state |
| cur_priv | input | 1 | 1 = privileged mode |
| mon_entry | input | 1 | Abort causes monitor entry |
| ea_route_mon | input | 1 | External aborts routed to monitor |
| reg_rd_en | input | 1 | Software read request |
| reg_wr_en | input | 1 | Software write request |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Registered read data |
| reg_acc_err | output | 1 | Unprivileged access flagged |

## Verification
Directed patterns cover the following cases, each compared with a bench model:
- precise external and non-external aborts, which separate correct field placement from correct zeroing of bit 12;
- imprecise aborts over a copy already filled with data, which shows whether the upper fields are kept;
- aborts in each security state with routing on and off, which shows which copy is chosen;
- write data of all ones, which exposes reserved bits that leak through;
- a capture and a write in the same cycle to the same copy and to opposite copies, which confirms the collision rule.

Constrained random cycles then mix all of these inputs, and every cycle is checked against the model's read data and error flag.

// File: rtl/fsr_pkg.sv
// Package: shared constants and types for the banked fault status register.
// Assumes a 32-bit record with fixed field positions.
package fsr_pkg;
    localparam int FSR_W      = 32;
    localparam int CODE_W     = 4;
    localparam int DOM_W      = 4;
    localparam int DOM_LSB    = CODE_W;
    localparam int XS_BIT     = 10;
    localparam int DIR_BIT    = 11;
    localparam int SLV_BIT    = 12;
    localparam int NUM_COPIES = 2;
    localparam int SEC_IDX    = 1;
    localparam int NS_IDX     = 0;

    // Bits that software may write and that captures may set.
    localparam logic [FSR_W-1:0] LIVE_MASK =
        (FSR_W'(1) << SLV_BIT) | (FSR_W'(1) << DIR_BIT) | (FSR_W'(1) << XS_BIT) |
        ((FSR_W'(1) << (DOM_LSB + DOM_W)) - FSR_W'(1));

    localparam logic [FSR_W-1:0] CODE_MASK = (FSR_W'(1) << CODE_W) - FSR_W'(1);

    typedef struct packed {
        logic             valid;
        logic             to_secure;
        logic             code_only;
        logic [FSR_W-1:0] word;
    } capture_t;
endpackage

// File: rtl/fsr_capture.sv
// Module: fsr_capture
// Builds the capture record and picks its target copy from an abort event.
// Assumes that at most one abort is presented per cycle; priority is resolved upstream.
module fsr_capture
    import fsr_pkg::*;
(
    input  logic              abt_valid,
    input  logic [CODE_W-1:0] abt_code,
    input  logic              abt_code_ext,
    input  logic [DOM_W-1:0]  abt_domain,
    input  logic              abt_write,
    input  logic              abt_slave_err,
    input  logic              abt_imprecise,
    input  logic              abt_external,
    input  logic              cur_secure,
    input  logic              mon_entry,
    input  logic              ea_route_mon,
    output capture_t          cap
);
    logic force_secure;

    // Purpose: an external abort routed to monitor always lands in the Secure copy.
    always_comb force_secure = mon_entry & ea_route_mon & abt_external;

    // Purpose: assemble the record word and the target copy.
    always_comb begin
        cap           = '0;
        cap.valid     = abt_valid;
        cap.to_secure = cur_secure | force_secure;
        cap.code_only = abt_imprecise;
        cap.word[CODE_W-1:0]              = abt_code;
        cap.word[DOM_LSB +: DOM_W]        = abt_domain;
        cap.word[XS_BIT]                  = abt_code_ext;
        cap.word[DIR_BIT]                 = abt_write;
        cap.word[SLV_BIT]                 = abt_external & abt_slave_err;
    end
endmodule

// File: rtl/fsr_bank.sv
// Module: fsr_bank
// One copy of the fault status record. A capture has priority over a software write.
// Assumes sw_word has already been masked to the writable bits.
module fsr_bank
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             cap_code_only,
    input  logic [FSR_W-1:0] cap_word,
    input  logic             sw_en,
    input  logic [FSR_W-1:0] sw_word,
    output logic [FSR_W-1:0] q
);
    logic [FSR_W-1:0] nxt;

    // Purpose: choose next contents; a capture wins over a write.
    always_comb begin
        nxt = q;
        if (cap_en) begin
            if (cap_code_only) nxt = (q & ~CODE_MASK) | (cap_word & CODE_MASK);
            else               nxt = cap_word;
        end else if (sw_en) begin
            nxt = sw_word;
        end
    end

    // Purpose: state register with reserved bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt & LIVE_MASK;
    end
endmodule

// File: rtl/fsr_access.sv
// Module: fsr_access
// Register-access port: privilege check, write steering, registered read.
// Assumes the read returns the copy's contents from before the same edge's update.
module fsr_access
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd_en,
    input  logic             reg_wr_en,
    input  logic [FSR_W-1:0] reg_wdata,
    input  logic             cur_secure,
    input  logic             cur_priv,
    input  logic [FSR_W-1:0] sec_q,
    input  logic [FSR_W-1:0] ns_q,
    output logic             sw_en_sec,
    output logic             sw_en_ns,
    output logic [FSR_W-1:0] sw_word,
    output logic [FSR_W-1:0] reg_rdata,
    output logic             reg_acc_err
);
    logic             wr_ok;
    logic [FSR_W-1:0] sel_q;

    // Purpose: gate writes by privilege and steer them to the current copy.
    always_comb begin
        wr_ok     = reg_wr_en & cur_priv;
        sw_en_sec = wr_ok & cur_secure;
        sw_en_ns  = wr_ok & ~cur_secure;
        sw_word   = reg_wdata & LIVE_MASK;
        sel_q     = cur_secure ? sec_q : ns_q;
    end

    // Purpose: registered read data and access-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata   <= '0;
            reg_acc_err <= 1'b0;
        end else begin
            reg_acc_err <= (reg_rd_en | reg_wr_en) & ~cur_priv;
            if (reg_rd_en) reg_rdata <= cur_priv ? sel_q : '0;
        end
    end
endmodule

// File: rtl/fault_status_bank.sv
// Module: fault_status_bank (top)
// Holds the Secure and Non-secure data fault records, with hardware capture and privileged access.
// Assumes synchronous active-low reset and one abort per cycle.
module fault_status_bank
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abt_valid,
    input  logic [3:0]        abt_code,
    input  logic              abt_code_ext,
    input  logic [3:0]        abt_domain,
    input  logic              abt_write,
    input  logic              abt_slave_err,
    input  logic              abt_imprecise,
    input  logic              abt_external,
    input  logic              cur_secure,
    input  logic              cur_priv,
    input  logic              mon_entry,
    input  logic              ea_route_mon,
    input  logic              reg_rd_en,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_acc_err
);
    capture_t         cap;
    logic             sw_en_sec;
    logic             sw_en_ns;
    logic [FSR_W-1:0] sw_word;
    logic [FSR_W-1:0] bank_q [NUM_COPIES];

    fsr_capture u_cap (
        .abt_valid     (abt_valid),
        .abt_code      (abt_code),
        .abt_code_ext  (abt_code_ext),
        .abt_domain    (abt_domain),
        .abt_write     (abt_write),
        .abt_slave_err (abt_slave_err),
        .abt_imprecise (abt_imprecise),
        .abt_external  (abt_external),
        .cur_secure    (cur_secure),
        .mon_entry     (mon_entry),
        .ea_route_mon  (ea_route_mon),
        .cap           (cap)
    );

    fsr_access u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_rd_en   (reg_rd_en),
        .reg_wr_en   (reg_wr_en),
        .reg_wdata   (reg_wdata),
        .cur_secure  (cur_secure),
        .cur_priv    (cur_priv),
        .sec_q       (bank_q[SEC_IDX]),
        .ns_q        (bank_q[NS_IDX]),
        .sw_en_sec   (sw_en_sec),
        .sw_en_ns    (sw_en_ns),
        .sw_word     (sw_word),
        .reg_rdata   (reg_rdata),
        .reg_acc_err (reg_acc_err)
    );

    // One copy per security state; index SEC_IDX is Secure.
    for (genvar gi = 0; gi < NUM_COPIES; gi++) begin : g_copy
        logic hit;
        logic sw_hit;
        // Purpose: decode capture and write enables for this copy.
        always_comb begin
            hit    = cap.valid & (cap.to_secure == (gi == SEC_IDX));
            sw_hit = (gi == SEC_IDX) ? sw_en_sec : sw_en_ns;
        end
        fsr_bank u_bank (
            .clk           (clk),
            .rst_n         (rst_n),
            .cap_en        (hit),
            .cap_code_only (cap.code_only),
            .cap_word      (cap.word),
            .sw_en         (sw_hit),
            .sw_word       (sw_word),
            .q             (bank_q[gi])
        );
    end
endmodule

// File: rtl/fault_status_bank_chk.sv
// Module: fault_status_bank_chk
// Property checker bound to fault_status_bank; observes ports and the two copies.
module fault_status_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        abt_valid,
    input logic [3:0]  abt_code,
    input logic        abt_imprecise,
    input logic        abt_external,
    input logic        cur_secure,
    input logic        cur_priv,
    input logic        mon_entry,
    input logic        ea_route_mon,
    input logic        reg_rd_en,
    input logic        reg_wr_en,
    input logic [31:0] reg_rdata,
    input logic        reg_acc_err,
    input logic [31:0] bank_q [2]
);
    logic tgt_sec;
    // Purpose: expected target copy of a capture, derived from ports.
    always_comb tgt_sec = cur_secure | (mon_entry & ea_route_mon & abt_external);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:13] == '0 && reg_rdata[9:8] == '0);

    assert_unpriv_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en || reg_wr_en) && !cur_priv |=> reg_acc_err);

    assert_unpriv_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en && !cur_priv |=> reg_rdata == '0);

    assert_imprecise_keep_sec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && abt_imprecise && tgt_sec |=> bank_q[1][12:4] == $past(bank_q[1][12:4]));

    assert_imprecise_keep_ns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && abt_imprecise && !tgt_sec |=> bank_q[0][12:4] == $past(bank_q[0][12:4]));

    assert_nonext_slave_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && !abt_imprecise && !abt_external && tgt_sec |=> !bank_q[1][12]);

    assert_route_ns_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && mon_entry && ea_route_mon && abt_external && !(reg_wr_en && cur_priv)
        |=> $stable(bank_q[0]));

    assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && reg_wr_en && cur_priv && (tgt_sec == cur_secure)
        |=> ($past(tgt_sec) ? bank_q[1][3:0] : bank_q[0][3:0]) == $past(abt_code));
endmodule

bind fault_status_bank fault_status_bank_chk u_chk (.*);

// File: tb/fault_status_bank_tb.sv
module fault_status_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] WMASK = 32'h0000_1CFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abt_valid = 0, abt_code_ext = 0, abt_write = 0, abt_slave_err = 0;
    logic        abt_imprecise = 0, abt_external = 0, cur_secure = 0, cur_priv = 0;
    logic        mon_entry = 0, ea_route_mon = 0, reg_rd_en = 0, reg_wr_en = 0;
    logic [3:0]  abt_code = 0, abt_domain = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        reg_acc_err;

    int          n_chk = 0, n_bad = 0;
    logic [31:0] m_bank [2];
    logic [31:0] e_rdata = 0;
    logic        e_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_bank u_dut (.*);

    function automatic logic [31:0] cap_word(logic ext, logic slv, logic wr, logic xs,
                                             logic [3:0] dom, logic [3:0] code);
        return {19'b0, ext & slv, wr, xs, 2'b00, dom, code};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one edge, updating the model; compare at the next negedge.
    task automatic step(string tag);
        logic tgt;
        e_err = (reg_rd_en | reg_wr_en) & ~cur_priv;
        if (reg_rd_en) e_rdata = cur_priv ? m_bank[cur_secure] : 32'h0;
        tgt = cur_secure | (mon_entry & ea_route_mon & abt_external);
        if (reg_wr_en && cur_priv && !(abt_valid && tgt == cur_secure))
            m_bank[cur_secure] = reg_wdata & WMASK;
        if (abt_valid) begin
            if (abt_imprecise) m_bank[tgt] = {m_bank[tgt][31:4], abt_code};
            else m_bank[tgt] = cap_word(abt_external, abt_slave_err, abt_write,
                                        abt_code_ext, abt_domain, abt_code);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, reg_rdata, e_rdata);
        check(tag, {31'b0, reg_acc_err}, {31'b0, e_err});
    endtask

    task automatic idle();
        abt_valid = 0; reg_rd_en = 0; reg_wr_en = 0; mon_entry = 0; ea_route_mon = 0;
        abt_imprecise = 0; abt_external = 0; abt_slave_err = 0;
    endtask

    task automatic rd(string tag, logic sec);
        idle(); cur_priv = 1; cur_secure = sec; reg_rd_en = 1; step(tag); idle();
    endtask

    task automatic abort(logic sec, logic ext, logic slv, logic imp, logic [3:0] code,
                         logic [3:0] dom, logic wr, logic xs);
        idle(); cur_secure = sec; abt_valid = 1; abt_external = ext; abt_slave_err = slv;
        abt_imprecise = imp; abt_code = code; abt_domain = dom; abt_write = wr;
        abt_code_ext = xs;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        m_bank[0] = 0; m_bank[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        check("R1", reg_rdata, 32'h0);
        check("R1", {31'b0, reg_acc_err}, 32'h0);
        rd("R1", 1'b0); rd("R1", 1'b1);

        // R2: precise external abort, Non-secure
        abort(0, 1, 1, 0, 4'h8, 4'hA, 1, 1); step("R2"); rd("R2", 1'b0);
        // R5: Secure copy untouched
        rd("R5", 1'b1);
        // R3: non-external abort with slave flag set stores bit 12 as zero
        abort(1, 0, 1, 0, 4'h5, 4'h3, 1, 0); step("R3"); rd("R3", 1'b1);
        // R4: imprecise abort keeps upper fields
        abort(1, 1, 0, 1, 4'h6, 4'hF, 0, 1); step("R4"); rd("R4", 1'b1);
        // R6: routed external abort from Non-secure lands in Secure copy
        abort(0, 1, 1, 0, 4'hC, 4'h7, 0, 0); mon_entry = 1; ea_route_mon = 1;
        step("R6"); rd("R6", 1'b1); rd("R6", 1'b0);
        // R5: routing off keeps Non-secure target
        abort(0, 1, 0, 0, 4'h2, 4'h1, 1, 0); mon_entry = 1; step("R5"); rd("R5", 1'b0);
        // R7: write all ones, reserved bits discarded
        idle(); cur_priv = 1; cur_secure = 1; reg_wr_en = 1; reg_wdata = 32'hFFFF_FFFF;
        step("R7"); rd("R7", 1'b1);
        // R8: unprivileged read returns zero
        idle(); cur_priv = 0; cur_secure = 1; reg_rd_en = 1; step("R8");
        // R9: unprivileged write has no effect
        idle(); cur_priv = 0; cur_secure = 0; reg_wr_en = 1; reg_wdata = 32'h0000_1CFF;
        step("R9"); rd("R9", 1'b0);
        // R10: collision on same copy, capture wins
        abort(0, 0, 0, 0, 4'h9, 4'h4, 0, 0); cur_priv = 1; reg_wr_en = 1;
        reg_wdata = 32'h0000_0C33; step("R10"); rd("R10", 1'b0);
        // R10: capture to Secure copy, write to Non-secure copy both land
        abort(0, 1, 1, 0, 4'hD, 4'hE, 1, 1); mon_entry = 1; ea_route_mon = 1;
        cur_priv = 1; reg_wr_en = 1; reg_wdata = 32'h0000_0811;
        step("R10"); rd("R10", 1'b1); rd("R10", 1'b0);

        // Random mix, R8/R9 observed every cycle
        for (int i = 0; i < 3000; i++) begin
            abt_valid     = ($urandom_range(0, 2) == 0);
            abt_code      = 4'($urandom);
            abt_domain    = 4'($urandom);
            abt_code_ext  = 1'($urandom);
            abt_write     = 1'($urandom);
            abt_slave_err = 1'($urandom);
            abt_imprecise = ($urandom_range(0, 3) == 0);
            abt_external  = 1'($urandom);
            cur_secure    = 1'($urandom);
            cur_priv      = ($urandom_range(0, 3) != 0);
            mon_entry     = 1'($urandom);
            ea_route_mon  = 1'($urandom);
            reg_rd_en     = 1'($urandom);
            reg_wr_en     = ($urandom_range(0, 2) == 0);
            reg_wdata     = $urandom;
            step("R8");
        end
        idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule